// File: doc/BRIEF.md
# SPI Master Controller with Register Access

This block is a serial-peripheral-interface master that software drives through a small word-addressed register space. Transmit words go into a transmit FIFO through a write window. Received words come out of a receive FIFO through a read window. A shift engine produces the serial clock, shifts data out on `mosi` and samples `miso`. It supports 8-bit and 16-bit frames, all four clock polarity and phase combinations, and a programmable clock divider.

Software configures the controller while it is disabled and then sets the enable register. The transfer-mode field selects one of three modes:

- full duplex, where each transmitted frame also stores a received frame;
- transmit-only, where received bits are thrown away;
- receive-only, where frames run without any transmit data.

The frame-count register holds the number of frames minus one. Once that many frames plus one have been shifted, the busy flag drops. Clearing the enable register empties both FIFOs, resets the frame counter and returns the serial clock to its idle level.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every configuration register reads 0, the status busy bit (offset 0x24, bit 0) is 0, both level registers (TX 0x1C, RX 0x20) read 0, `sclk` is 0 and `cs_n` is 2'b11.
- R2: Control 0 (0x00, bits [19:0]: mode [19:18], polarity bit 7, phase bit 6, size [1:0]), frame count (0x04, [15:0]), enable (0x08, bit 0), select (0x0C, [1:0]), divider (0x10, [15:0]) and the two thresholds (0x14, 0x18, [4:0]) read back what was written.
- R3: With frame count N the engine shifts exactly N+1 frames (2·width `sclk` transitions each) and then clears busy while still enabled.
- R4: Writing 0 to the enable register empties both FIFOs and returns `sclk` to the polarity bit.
- R5: One `sclk` half-period lasts max(divider,2)/2 system clocks, using integer division.
- R6: A write to the TX window (0x400–0x7FC) while the TX FIFO holds 32 entries is dropped, and the level stays 32.
- R7: A read from the RX window (0x800–0xBFC) with an empty RX FIFO returns 0 and the level stays 0.
- R8: In receive-only mode (mode 2) frames run with an empty TX FIFO, `mosi` stays 0, and each frame stores the `miso` bits, MSB first, into the RX FIFO.
- R9: While enabled, writes to control 0, frame count, divider and thresholds are ignored.
- R10: In full-duplex mode (mode 0), with `miso` tied to `mosi`, every word written is received back unchanged for size code 1 (8-bit, low byte) and size code 2 (16-bit), under every polarity/phase combination. After the frame `sclk` rests at the polarity level.
- R11: In transmit-only mode (mode 1) nothing enters the RX FIFO. Busy stays set while fewer than N+1 frames have been sent, including while waiting for TX data.
- R12: `cs_n[i]` is the inverse of select register bit i at all times. Writing 0 deasserts both.
- R13: Writes to the TX window while disabled are dropped. Size codes 0 and 3 behave as 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; pops the RX FIFO on an RX-window access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
The hardest state to reach from the ports is a full TX FIFO while the controller is enabled, because a running engine drains that FIFO as fast as it is filled. The bench reaches it by enabling receive-only mode with the slowest divider and the largest frame count. In that mode the engine never pops TX data, so 34 writes fill the FIFO and overflow it. The same long-running state is then reused to attempt configuration writes while enabled and to check that disabling flushes the FIFOs and parks the clock at a high polarity. Exact frame counts are checked by counting `sclk` transitions in the bench.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
// Shared types and register offsets for the SPI master controller.
// Assumes word-aligned 12-bit byte addresses.
package spim_pkg;
    typedef enum logic [1:0] {
        XM_DUPLEX = 2'd0,
        XM_TXONLY = 2'd1,
        XM_RXONLY = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    localparam logic [11:0] OFF_CTL0  = 12'h000;
    localparam logic [11:0] OFF_COUNT = 12'h004;
    localparam logic [11:0] OFF_EN    = 12'h008;
    localparam logic [11:0] OFF_SEL   = 12'h00C;
    localparam logic [11:0] OFF_DIV   = 12'h010;
    localparam logic [11:0] OFF_TXTH  = 12'h014;
    localparam logic [11:0] OFF_RXTH  = 12'h018;
    localparam logic [11:0] OFF_TXLVL = 12'h01C;
    localparam logic [11:0] OFF_RXLVL = 12'h020;
    localparam logic [11:0] OFF_STAT  = 12'h024;
    localparam logic [1:0]  WIN_TX    = 2'b01;
    localparam logic [1:0]  WIN_RX    = 2'b10;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with flush. Push is ignored when full and pop is
// ignored when empty. rdata shows the head entry while not empty.
module spim_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    output logic [DW-1:0]              rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];
    assign level   = cnt_q;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    // R6: a push into a full FIFO leaves it full and loses nothing.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == (AW+1)'(DEPTH)));
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
// Serial shift engine: makes sclk from the half-period count, shifts
// frames MSB first and counts frames up to last_idx+1. It assumes the
// configuration inputs stay stable while en is high, and that half >= 1.
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  xfer_mode_e    mode,
    input  logic          wide,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [CW-1:0] half,
    input  logic [CW-1:0] last_idx,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          busy
);
    localparam int EW = $clog2(2*DW);
    localparam int HW = DW/2;

    logic          run_q, pend_q, done_q, phase_q, mosi_q;
    logic [CW-1:0] hcnt_q, frames_q;
    logic [EW-1:0] edge_q;
    logic [DW-1:0] sh_out_q, sh_in_q;
    logic          need_tx, keep_rx, start_ok, tick, lead;
    logic [EW-1:0] last_edge;
    logic [DW-1:0] word, loaded;

    assign need_tx   = (mode != XM_RXONLY);
    assign keep_rx   = (mode != XM_TXONLY);
    assign start_ok  = en && !done_q && !run_q && !pend_q
                       && !(need_tx && tx_empty) && !(keep_rx && rx_full);
    assign tx_pop    = start_ok && need_tx;
    assign word      = need_tx ? tx_data : '0;
    assign loaded    = wide ? word : {word[HW-1:0], {HW{1'b0}}};
    assign tick      = run_q && (hcnt_q == half - CW'(1));
    assign lead      = !edge_q[0];
    assign last_edge = wide ? EW'(2*DW-1) : EW'(DW-1);
    assign rx_push   = pend_q;
    assign rx_data   = wide ? sh_in_q : {{HW{1'b0}}, sh_in_q[HW-1:0]};
    assign sclk      = cpol ^ phase_q;
    assign mosi      = mosi_q;
    assign busy      = run_q || pend_q || (en && !done_q);

    // Frame sequencing, clock edges, shifting and frame counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q    <= 1'b0;
            pend_q   <= 1'b0;
            done_q   <= 1'b0;
            phase_q  <= 1'b0;
            mosi_q   <= 1'b0;
            hcnt_q   <= '0;
            frames_q <= '0;
            edge_q   <= '0;
            sh_out_q <= '0;
            sh_in_q  <= '0;
        end else begin
            pend_q <= 1'b0;
            if (start_ok) begin
                run_q  <= 1'b1;
                hcnt_q <= '0;
                edge_q <= '0;
                if (!cpha) begin
                    mosi_q   <= loaded[DW-1];
                    sh_out_q <= loaded << 1;
                end else begin
                    sh_out_q <= loaded;
                end
            end else if (tick) begin
                hcnt_q  <= '0;
                phase_q <= !phase_q;
                edge_q  <= edge_q + EW'(1);
                if (lead != cpha) sh_in_q <= {sh_in_q[DW-2:0], miso};
                else begin
                    mosi_q   <= sh_out_q[DW-1];
                    sh_out_q <= sh_out_q << 1;
                end
                if (edge_q == last_edge) begin
                    run_q    <= 1'b0;
                    pend_q   <= keep_rx;
                    frames_q <= frames_q + CW'(1);
                    if (frames_q == last_idx) done_q <= 1'b1;
                end
            end else if (run_q) begin
                hcnt_q <= hcnt_q + CW'(1);
            end
        end
    end

    // R4: one cycle after a disabled cycle the clock rests at its polarity.
    a_r4_idle_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (en || sclk == cpol));
    // R8: receive-only mode never consumes transmit data.
    a_r8_no_tx_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_RXONLY) |-> !tx_pop);
    // R3: no frame runs once the programmed count has been reached.
    a_r3_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en) |-> (frames_q <= last_idx));
    // R11: in transmit-only mode the RX FIFO receives nothing.
    a_r11_no_rx_push: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XM_TXONLY && $stable(mode)) |-> !rx_push);
endmodule

// File: rtl/spi_regmaster.sv
`timescale 1ns/1ps
// SPI master with a word-addressed register space, TX and RX FIFOs and
// a shift engine. Configuration is writable only while disabled.
// reg_rdata is combinational; reg_rd pops the RX FIFO on RX-window reads.
module spi_regmaster
    import spim_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int NSEL  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [1:0]  cs_n
);
    localparam int LW  = $clog2(DEPTH) + 1;
    localparam int THW = $clog2(DEPTH);

    logic [19:0]     ctl0_q;
    logic [CW-1:0]   count_q, div_q;
    logic            en_q;
    logic [NSEL-1:0] sel_q;
    logic [THW-1:0]  txth_q, rxth_q;

    logic            cfg_ok, tx_win, rx_win, busy;
    logic            tx_push, tx_pop, tx_full, tx_empty;
    logic            rx_push, rx_pop, rx_full, rx_empty;
    logic [DW-1:0]   tx_head, rx_head, rx_word;
    logic [LW-1:0]   tx_lvl, rx_lvl;
    logic [CW-1:0]   half;
    logic            unused_bits;

    assign cfg_ok  = !en_q;
    assign tx_win  = (reg_addr[11:10] == WIN_TX);
    assign rx_win  = (reg_addr[11:10] == WIN_RX);
    assign tx_push = reg_wr && tx_win && en_q;
    assign rx_pop  = reg_rd && rx_win;
    assign half    = (div_q < CW'(2)) ? CW'(1) : (div_q >> 1);
    assign cs_n    = ~sel_q;
    assign unused_bits = ^{reg_wdata[31:20], reg_addr[1:0]};

    // Register writes; configuration only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q  <= '0;
            count_q <= '0;
            en_q    <= 1'b0;
            sel_q   <= '0;
            div_q   <= '0;
            txth_q  <= '0;
            rxth_q  <= '0;
        end else if (reg_wr && !tx_win && !rx_win) begin
            case (reg_addr)
                OFF_CTL0:  if (cfg_ok) ctl0_q  <= reg_wdata[19:0];
                OFF_COUNT: if (cfg_ok) count_q <= reg_wdata[CW-1:0];
                OFF_EN:    en_q <= reg_wdata[0];
                OFF_SEL:   sel_q <= reg_wdata[NSEL-1:0];
                OFF_DIV:   if (cfg_ok) div_q   <= reg_wdata[CW-1:0];
                OFF_TXTH:  if (cfg_ok) txth_q  <= reg_wdata[THW-1:0];
                OFF_RXTH:  if (cfg_ok) rxth_q  <= reg_wdata[THW-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (rx_win) reg_rdata = rx_empty ? 32'd0 : 32'(rx_head);
        else if (!tx_win) begin
            case (reg_addr)
                OFF_CTL0:  reg_rdata = 32'(ctl0_q);
                OFF_COUNT: reg_rdata = 32'(count_q);
                OFF_EN:    reg_rdata = 32'(en_q);
                OFF_SEL:   reg_rdata = 32'(sel_q);
                OFF_DIV:   reg_rdata = 32'(div_q);
                OFF_TXTH:  reg_rdata = 32'(txth_q);
                OFF_RXTH:  reg_rdata = 32'(rxth_q);
                OFF_TXLVL: reg_rdata = 32'(tx_lvl);
                OFF_RXLVL: reg_rdata = 32'(rx_lvl);
                OFF_STAT:  reg_rdata = 32'(busy);
                default:   reg_rdata = '0;
            endcase
        end
    end

    spim_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(tx_push), .wdata(reg_wdata[DW-1:0]),
        .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl));

    spim_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl));

    spim_shifter #(.DW(DW), .CW(CW)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .mode(xfer_mode_e'(ctl0_q[19:18])),
        .wide(ctl0_q[1:0] == 2'd2),
        .cpol(ctl0_q[7]), .cpha(ctl0_q[6]),
        .half(half), .last_idx(count_q),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy));

    // R9: control 0 does not change under a write while enabled.
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && reg_wr && reg_addr == OFF_CTL0) |=> $stable(ctl0_q));
    // R4: a disabled controller reports idle one cycle later.
    a_r4_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (en_q || !busy));
    // R12: chip selects track the select register.
    a_r12_cs_track: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_SEL) |=> (cs_n == ~$past(reg_wdata[1:0])));
endmodule

// File: tb/spi_regmaster_test.sv
`timescale 1ns/1ps
module spi_regmaster_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [1:0]  cs_n;
    logic        miso_force = 1'b0;
    logic        miso_val = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    int toggles = 0;
    bit mosi_high = 0;
    longint t_last = 0, t_prev = 0;

    assign miso = miso_force ? miso_val : mosi;

    always #2 clk = ~clk;

    spi_regmaster uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    always @(sclk) begin
        toggles = toggles + 1;
        t_prev = t_last;
        t_last = $time;
    end

    always @(posedge mosi) mosi_high = 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(12'h024, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    // fields: [27] wide, [26] cpol, [25] cpha, [23:16] divider, [15:0] data
    localparam logic [27:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 16'h00A5},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 16'h003C},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 16'h0081},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 16'h007E},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd7, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd5, 16'h1234}
    };

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, d); check("R1 ctl0", d, 0);
        rd(12'h008, d); check("R1 enable", d, 0);
        rd(12'h024, d); check("R1 busy", d, 0);
        rd(12'h01C, d); check("R1 txlvl", d, 0);
        rd(12'h020, d); check("R1 rxlvl", d, 0);
        check("R1 sclk", {31'd0, sclk}, 0);
        check("R1 cs_n", {30'd0, cs_n}, 32'd3);

        // R2 register readback
        wr(12'h004, 32'h0000_1234); rd(12'h004, d); check("R2 count", d, 32'h1234);
        wr(12'h010, 32'h0000_00A7); rd(12'h010, d); check("R2 divider", d, 32'hA7);
        wr(12'h014, 32'h0000_000F); rd(12'h014, d); check("R2 txth", d, 32'hF);
        wr(12'h018, 32'h0000_0011); rd(12'h018, d); check("R2 rxth", d, 32'h11);
        wr(12'h000, 32'h0008_24C1); rd(12'h000, d); check("R2 ctl0", d, 32'h0008_24C1);

        // R12 chip selects
        wr(12'h00C, 32'd2); check("R12 cs one", {30'd0, cs_n}, 32'd1);
        wr(12'h00C, 32'd0); check("R12 cs none", {30'd0, cs_n}, 32'd3);

        // R13 TX write while disabled is dropped
        wr(12'h400, 32'h55); rd(12'h01C, d); check("R13 tx while off", d, 0);

        // R10 / R5 duplex vector walk with loopback
        foreach (VEC[k]) begin
            logic [27:0] v;
            logic [31:0] expd;
            int half, w;
            v = VEC[k];
            w = v[27] ? 16 : 8;
            half = (v[23:16] < 2) ? 1 : (v[23:16] / 2);
            expd = v[27] ? {16'd0, v[15:0]} : {24'd0, v[7:0]};
            wr(12'h008, 0);
            wr(12'h000, {12'd0, 2'd0, 10'd0, v[26], v[25], 4'd0, (v[27] ? 2'd2 : 2'd1)});
            wr(12'h004, 0);
            wr(12'h010, {24'd0, v[23:16]});
            toggles = 0;
            wr(12'h008, 1);
            wr(12'h400, {16'd0, v[15:0]});
            wait_idle();
            rd(12'h800, d); check($sformatf("R10 loopback v%0d", k), d, expd);
            check($sformatf("R3 toggles v%0d", k), toggles, 2 * w);
            check($sformatf("R10 sclk rest v%0d", k), {31'd0, sclk}, {31'd0, v[26]});
            check($sformatf("R5 half v%0d", k), 32'(t_last - t_prev), 32'(half * 4));
        end

        // R3 / R8 / R7 receive-only, three frames, miso high
        wr(12'h008, 0);
        miso_force = 1'b1; miso_val = 1'b1;
        wr(12'h000, 32'h0008_0001);
        wr(12'h004, 2);
        wr(12'h010, 2);
        toggles = 0; mosi_high = 0;
        wr(12'h008, 1);
        wait_idle();
        check("R3 rx-only toggles", toggles, 48);
        rd(12'h020, d); check("R8 rx level", d, 3);
        check("R8 mosi low", {31'd0, mosi_high}, 0);
        for (int i = 0; i < 3; i++) begin
            rd(12'h800, d); check("R8 rx word", d, 32'hFF);
        end
        rd(12'h800, d); check("R7 empty read", d, 0);
        rd(12'h020, d); check("R7 level stays", d, 0);

        // R11 transmit-only, two frames
        wr(12'h008, 0);
        miso_val = 1'b1;
        wr(12'h000, 32'h0004_0001);
        wr(12'h004, 1);
        wr(12'h010, 2);
        wr(12'h008, 1);
        wr(12'h400, 32'h55);
        repeat (200) @(negedge clk);
        rd(12'h024, d); check("R11 busy waiting", d, 1);
        wr(12'h400, 32'h66);
        wait_idle();
        rd(12'h024, d); check("R11 busy cleared", d, 0);
        rd(12'h020, d); check("R11 rx empty", d, 0);

        // R6 / R9 / R4 full TX FIFO in a long receive-only run
        wr(12'h008, 0);
        miso_val = 1'b0;
        wr(12'h000, 32'h0008_0081);
        wr(12'h004, 32'hFFFF);
        wr(12'h010, 32'hFFFF);
        wr(12'h008, 1);
        for (int i = 0; i < 34; i++) wr(12'h400, 32'(i));
        rd(12'h01C, d); check("R6 tx full", d, 32);
        wr(12'h000, 32'h0000_0002); rd(12'h000, d); check("R9 ctl0 locked", d, 32'h0008_0081);
        wr(12'h010, 32'd6); rd(12'h010, d); check("R9 divider locked", d, 32'hFFFF);
        wr(12'h004, 32'd3); rd(12'h004, d); check("R9 count locked", d, 32'hFFFF);
        rd(12'h024, d); check("R3 busy running", d, 1);
        wr(12'h008, 0);
        rd(12'h01C, d); check("R4 tx flushed", d, 0);
        rd(12'h020, d); check("R4 rx flushed", d, 0);
        check("R4 sclk idle high", {31'd0, sclk}, 1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule